// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steps a processor subsystem between three operating states: full-speed run, a wait state that the core enters to sleep until an interrupt is serviced, and a halt state that stops everything. The core raises single-cycle mode requests. The interrupt controller raises an acknowledge. A watchdog-enabled flag decides whether halt is allowed. From these inputs the block produces a CPU clock enable, a peripheral/interrupt-domain clock enable, and a global control that puts the I/O pads into high impedance.

In wait, the CPU enable is low and the peripheral domain keeps running at a reduced rate. A 3-bit divider setting, captured when the wait request is accepted, selects that rate. The peripheral enable is then a one-cycle pulse every 2^d cycles. Halt stops both domains, tri-states the I/O, and can be left only through the synchronous reset. The block works at the level of enables. Clock gating cells, clock generation, the watchdog counter and the interrupt controller are outside it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cpu_clk_en` = 1, `per_clk_en` = 1 and `io_hiz` = 0, whatever state the block was in before.
- R2: In run, `cpu_clk_en` and `per_clk_en` are both high every cycle. `irq_ack` in run leaves the block in run.
- R3: A `wfi_req` sampled in run, with no permitted halt request in the same cycle, drives `cpu_clk_en` low from the next cycle. It stays low until an acknowledge ends the wait state.
- R4: An `irq_ack` sampled in wait returns the block to run in the next cycle (both enables high). `wfi_req` and `halt_req` sampled in wait are ignored.
- R5: `div_sel` = d (3 bits, period P = 2^d, so 1 to 128) is sampled in the cycle the wait request is accepted. Wait cycles are numbered j = 0, 1, 2, … starting with the first wait cycle. `per_clk_en` is high in wait cycle j exactly when j mod P = 0.
- R6: Changes of `div_sel` while in wait do not alter the pulse pattern.
- R7: A `halt_req` sampled in run with `wdog_en` = 0 gives `cpu_clk_en` = 0, `per_clk_en` = 0 and `io_hiz` = 1 from the next cycle.
- R8: A `halt_req` sampled in run with `wdog_en` = 1 is ignored and `io_hiz` stays 0. A `wfi_req` in the same cycle is still taken.
- R9: When `halt_req` and `wfi_req` are sampled together in run and halt is permitted, the block enters halt.
- R10: In halt, `wfi_req`, `halt_req` and `irq_ack` have no effect, and the halt outputs persist until `rst`.

Reset also clears the captured divider setting to divide-by-1. This cannot be seen at the ports, because every entry into wait loads a new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Core request to enter the wait state |
| halt_req | input | 1 | Core request to enter the halt state |
| irq_ack | input | 1 | Interrupt acknowledge from the interrupt controller |
| wdog_en | input | 1 | Watchdog running; blocks halt entry |
| div_sel | input | 3 | Peripheral rate in wait, period 2^div_sel cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral/interrupt-domain clock enable |
| io_hiz | output | 1 | Put all I/O pads into high impedance |

## Verification
Each state maps to a distinct output pattern, so a wrong state shows at the ports one cycle after the edge that produced it. Run shows both enables high. Wait shows the CPU enable low with peripheral pulses. Halt shows both enables low with `io_hiz` high. A wrong divider count or a stale divider value is subtler: it appears only as a misplaced peripheral pulse. It can take up to one full period (128 cycles at the slowest setting) before the pulse lands in the wrong cycle, so the slow settings are observed over at least two periods.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_HALT = 2'd2
  } pm_state_t;
endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wfi_req,
  input  logic      halt_req,
  input  logic      irq_ack,
  input  logic      wdog_en,
  output pm_state_t state_d,
  output logic      wait_entry
);
  pm_state_t state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN: begin
        if (halt_req && !wdog_en) state_d = PM_HALT;  // halt wins when allowed
        else if (wfi_req)         state_d = PM_WAIT;
      end
      PM_WAIT: if (irq_ack) state_d = PM_RUN;
      PM_HALT: state_d = PM_HALT;                     // only reset leaves
      default: state_d = PM_RUN;
    endcase
  end

  assign wait_entry = (state_q == PM_RUN) && (state_d == PM_WAIT);

  always_ff @(posedge clk) begin
    if (rst) state_q <= PM_RUN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pmc_clkdiv.sv
module pmc_clkdiv #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             active,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick_q
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] mask_of(input logic [DIV_W-1:0] d);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ones >> (CNT_W - int'(d));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load) begin
      div_q  <= div_sel;
      cnt_q  <= CNT_W'(1) & mask_of(div_sel);
      tick_q <= 1'b1;
    end else if (active) begin
      cnt_q  <= (cnt_q + CNT_W'(1)) & mask_of(div_q);
      tick_q <= (cnt_q == '0);
    end else begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_req,
  input  logic             halt_req,
  input  logic             irq_ack,
  input  logic             wdog_en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             io_hiz
);
  pm_state_t state_d;
  logic      wait_entry;
  logic      tick_q;
  logic      run_q;
  logic      hiz_q;

  pmc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wfi_req    (wfi_req),
    .halt_req   (halt_req),
    .irq_ack    (irq_ack),
    .wdog_en    (wdog_en),
    .state_d    (state_d),
    .wait_entry (wait_entry)
  );

  pmc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .load    (wait_entry),
    .active  (state_d == PM_WAIT),
    .div_sel (div_sel),
    .tick_q  (tick_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b1;
      hiz_q <= 1'b0;
    end else begin
      run_q <= (state_d == PM_RUN);
      hiz_q <= (state_d == PM_HALT);
    end
  end

  assign cpu_clk_en = run_q;
  assign per_clk_en = run_q | tick_q;
  assign io_hiz     = hiz_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic wfi_req,
  input logic halt_req,
  input logic irq_ack,
  input logic wdog_en,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic io_hiz
);
  a_r2_run_per: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> per_clk_en && !io_hiz);

  a_r3_wfi_stop: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && wfi_req && !(halt_req && !wdog_en)) |=> !cpu_clk_en && per_clk_en && !io_hiz);

  a_r3_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !io_hiz && !irq_ack) |=> !cpu_clk_en && !io_hiz);

  a_r4_wake: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !io_hiz && irq_ack) |=> cpu_clk_en && per_clk_en);

  a_r7_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && halt_req && !wdog_en) |=> io_hiz && !cpu_clk_en && !per_clk_en);

  a_r8_wdog_blocks: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && halt_req && wdog_en) |=> !io_hiz);

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    io_hiz |=> io_hiz && !cpu_clk_en && !per_clk_en);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wfi_req    (wfi_req),
  .halt_req   (halt_req),
  .irq_ack    (irq_ack),
  .wdog_en    (wdog_en),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .io_hiz     (io_hiz)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wfi_req = 1'b0, halt_req = 1'b0, irq_ack = 1'b0, wdog_en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       cpu_clk_en, per_clk_en, io_hiz;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .halt_req(halt_req),
    .irq_ack(irq_ack), .wdog_en(wdog_en), .div_sel(div_sel),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .io_hiz(io_hiz)
  );

  // {wfi, halt, ack, wdog, div[2:0], exp_cpu, exp_per, exp_hiz}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    10'b0000_000_110,  // R2 idle run
    10'b0010_000_110,  // R2 ack in run ignored
    10'b0101_000_110,  // R8 halt blocked by watchdog
    10'b1000_000_010,  // R3 enter wait, div 1
    10'b0000_000_010,  // R5 divide-by-1 pulses every cycle
    10'b0100_000_010,  // R4 halt request in wait ignored
    10'b0010_000_110,  // R4 ack wakes
    10'b1101_000_010,  // R8 wfi taken while halt blocked
    10'b0010_000_110,  // R4 ack wakes
    10'b1100_000_001,  // R9 halt beats wfi
    10'b0010_000_001,  // R10 ack in halt ignored
    10'b1000_000_001   // R10 wfi in halt ignored
  };
  localparam string TAG [NV] = '{"R2","R2","R8","R3","R5","R4","R4","R8","R4","R9","R10","R10"};

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {cpu,per,hiz} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wfi_req = 1'b0; halt_req = 1'b0; irq_ack = 1'b0; wdog_en = 1'b0;
  endtask

  task automatic enter_wait(input logic [2:0] d);
    wfi_req = 1'b1; div_sel = d;
    @(negedge clk);
    wfi_req = 1'b0;
  endtask

  task automatic wake();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R4", {cpu_clk_en, per_clk_en, io_hiz}, 3'b110);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    chk("R1", {cpu_clk_en, per_clk_en, io_hiz}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {cpu_clk_en, per_clk_en, io_hiz}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      {wfi_req, halt_req, irq_ack, wdog_en, div_sel} = VEC[i][9:3];
      @(negedge clk);
      chk(TAG[i], {cpu_clk_en, per_clk_en, io_hiz}, VEC[i][2:0]);
    end
    idle_inputs();
    repeat (3) begin
      @(negedge clk);
      chk("R10", {cpu_clk_en, per_clk_en, io_hiz}, 3'b001);
    end

    // R1: reset leaves halt
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {cpu_clk_en, per_clk_en, io_hiz}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {cpu_clk_en, per_clk_en, io_hiz}, 3'b110);

    // R5: divide-by-4 pattern
    enter_wait(3'd2);
    for (int j = 0; j < 12; j++) begin
      chk("R5", {cpu_clk_en, per_clk_en, io_hiz}, {1'b0, (j % 4) == 0, 1'b0});
      @(negedge clk);
    end
    wake();

    // R5: divide-by-128 over two periods
    enter_wait(3'd7);
    pulses = 0;
    for (int j = 0; j < 256; j++) begin
      if (per_clk_en) pulses++;
      if (j == 0 || j == 127 || j == 128)
        chk("R5", {cpu_clk_en, per_clk_en, io_hiz}, {1'b0, j != 127, 1'b0});
      @(negedge clk);
    end
    chk("R5", {1'b0, pulses == 2, 1'b0}, 3'b010);
    wake();

    // R6: divider change during wait ignored
    enter_wait(3'd1);
    div_sel = 3'd0;
    for (int j = 0; j < 8; j++) begin
      chk("R6", {cpu_clk_en, per_clk_en, io_hiz}, {1'b0, (j % 2) == 0, 1'b0});
      @(negedge clk);
    end
    wake();

    // R7: halt entry with watchdog off
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R7", {cpu_clk_en, per_clk_en, io_hiz}, 3'b001);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {cpu_clk_en, per_clk_en, io_hiz}, 3'b110);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule